// File: doc/BRIEF.md
# Multi-Endpoint MSI Interrupt Controller

This block sits beside a PCIe core and turns inbound message-signalled-interrupt writes into level interrupt state. Every inbound write whose 64-bit address equals a programmed target address is taken as an MSI. Its data word names an endpoint register and a bit within it, and that status bit is set if software has enabled it. Each endpoint register holds its own enable, mask and status words. Software reaches all of them over a simple word-addressed register bus, with combinational reads and single-cycle writes.

A bit is pending when its status is 1 and its mask is 0. One level interrupt output is the OR of every pending bit. A priority encoder names the pending bit that software should service first. It takes the lowest endpoint register first and, within it, the lowest bit. Software clears status by writing ones, so no read-modify-write is needed.

The block has no controlling state machine. Its only states are the register contents: target address, and enable, mask and status per endpoint register. Status moves between two states. A bit goes from idle to set when an enabled MSI arrives. It goes from set back to idle on a write-one-to-clear, unless an MSI for the same bit arrives in that cycle.

Top module: `msi_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_out` and `pend_valid` are 0, and `pend_ep`/`pend_bit` are 0.
- R2: An inbound write counts as an MSI only when `msi_addr[31:0]` equals the low target word and `msi_addr[63:32]` equals the high target word. A write that differs in either half changes no status bit.
- R3: For a matching MSI, `msi_data[7:5]` selects the endpoint register and `msi_data[4:0]` selects the bit. That status bit reads 1 from the cycle after the write.
- R4: An MSI whose selected enable bit is 0 is dropped, and its status bit stays 0.
- R5: Writing a word to a status register clears exactly the bits that are 1 in that word and leaves the others unchanged.
- R6: `irq_out` is 1 exactly when some status bit is 1 with its mask bit 0. A masked bit keeps its status but raises no interrupt.
- R7: When `pend_valid` is 1, `pend_ep` and `pend_bit` name the pending bit in the lowest-numbered endpoint register, taking the lowest bit within that register.
- R8: When an MSI sets a status bit in the same cycle that a software write clears it, the bit ends up set.
- R9: Register map, by word address: 0 = low target word, 1 = high target word, 4+4e = enable of endpoint e, 5+4e = mask of endpoint e, 6+4e = status of endpoint e. Reads return current values, and writes to enable, mask and the target words read back as written.
- R10: `irq_out` stays at 1 across cycles with no bus activity until the pending bits are cleared or masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Inbound write strobe from the PCIe core |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Aggregated level interrupt |
| pend_valid | output | 1 | A pending bit exists |
| pend_ep | output | 3 | Endpoint register of the first pending bit |
| pend_bit | output | 5 | Bit number of the first pending bit |

## Verification
Two functions can land in the same clock edge: an inbound MSI that sets a status bit, and a software write-one-to-clear aimed at that bit. The bench provokes this by driving `msi_valid` and a status write to the same endpoint register in one cycle, with the write data holding exactly the bit the MSI selects. It then reads the status back and expects the bit to be set. Other bits in that write are expected to clear as usual, so the rule is judged on one bit and not on the whole word.

// File: rtl/msi_ctrl_pkg.sv
package msi_ctrl_pkg;
    localparam int MAX_EP    = 8;
    localparam int EP_W      = 32;
    localparam int EP_IDX_W  = 3;
    localparam int BIT_IDX_W = 5;
    localparam int DW        = 32;
    localparam int REG_AW    = $clog2(4 + 4 * MAX_EP);
    localparam int GRP_W     = REG_AW - 2;

    typedef enum logic [1:0] {
        FLD_EN   = 2'd0,
        FLD_MASK = 2'd1,
        FLD_STAT = 2'd2,
        FLD_NONE = 2'd3
    } field_e;
endpackage

// File: rtl/msi_ep_bank.sv
module msi_ep_bank
    import msi_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic            mk_we,
    input  logic            st_we,
    input  logic [EP_W-1:0] wdata,
    input  logic [EP_W-1:0] set_req,
    output logic [EP_W-1:0] en_q,
    output logic [EP_W-1:0] mk_q,
    output logic [EP_W-1:0] st_q,
    output logic [EP_W-1:0] pend
);
    logic [EP_W-1:0] set_ok;
    logic [EP_W-1:0] clr_bits;
    logic [EP_W-1:0] st_d;

    always_comb begin
        set_ok   = set_req & en_q;
        clr_bits = st_we ? wdata : '0;
        // a set in the same cycle overrides a clear
        st_d     = (st_q & ~clr_bits) | set_ok;
        pend     = st_q & ~mk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            mk_q <= '0;
            st_q <= '0;
        end else begin
            if (en_we) en_q <= wdata;
            if (mk_we) mk_q <= wdata;
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/msi_prio_enc.sv
module msi_prio_enc
    import msi_ctrl_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic [NUM_EP*EP_W-1:0] pend,
    output logic                   valid,
    output logic [EP_IDX_W-1:0]    ep,
    output logic [BIT_IDX_W-1:0]   bit_no
);
    localparam int TOT = NUM_EP * EP_W;

    int sel;

    always_comb begin
        sel = 0;
        for (int i = TOT - 1; i >= 0; i--) begin
            if (pend[i]) sel = i;
        end
        valid  = |pend;
        ep     = EP_IDX_W'(sel / EP_W);
        bit_no = BIT_IDX_W'(sel % EP_W);
    end
endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
    import msi_ctrl_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    input  logic [63:0]          msi_addr,
    input  logic [31:0]          msi_data,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 irq_out,
    output logic                 pend_valid,
    output logic [EP_IDX_W-1:0]  pend_ep,
    output logic [BIT_IDX_W-1:0] pend_bit
);
    localparam int TOT = NUM_EP * EP_W;

    logic [DW-1:0]  addr_lo_q;
    logic [DW-1:0]  addr_hi_q;
    logic [TOT-1:0] en_all;
    logic [TOT-1:0] mk_all;
    logic [TOT-1:0] st_all;
    logic [TOT-1:0] pend_all;

    logic [GRP_W-1:0]     grp;
    field_e               fld;
    logic                 hit;
    logic [EP_IDX_W-1:0]  msi_ep;
    logic [BIT_IDX_W-1:0] msi_bit;

    assign grp     = reg_addr[REG_AW-1:2];
    assign fld     = field_e'(reg_addr[1:0]);
    assign hit     = msi_valid && (msi_addr[31:0] == addr_lo_q)
                               && (msi_addr[63:32] == addr_hi_q);
    assign msi_ep  = msi_data[7:5];
    assign msi_bit = msi_data[4:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else if (reg_we && grp == '0) begin
            if (reg_addr[1:0] == 2'd0) addr_lo_q <= reg_wdata;
            if (reg_addr[1:0] == 2'd1) addr_hi_q <= reg_wdata;
        end
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_bank
        logic            grp_hit;
        logic [EP_W-1:0] set_req;

        assign grp_hit = (grp == GRP_W'(e + 1));
        assign set_req = (hit && msi_ep == EP_IDX_W'(e))
                       ? (EP_W'(1) << msi_bit) : '0;

        msi_ep_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_we   (reg_we && grp_hit && fld == FLD_EN),
            .mk_we   (reg_we && grp_hit && fld == FLD_MASK),
            .st_we   (reg_we && grp_hit && fld == FLD_STAT),
            .wdata   (reg_wdata),
            .set_req (set_req),
            .en_q    (en_all[e*EP_W +: EP_W]),
            .mk_q    (mk_all[e*EP_W +: EP_W]),
            .st_q    (st_all[e*EP_W +: EP_W]),
            .pend    (pend_all[e*EP_W +: EP_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (grp == '0) begin
            if (reg_addr[1:0] == 2'd0) reg_rdata = addr_lo_q;
            if (reg_addr[1:0] == 2'd1) reg_rdata = addr_hi_q;
        end else begin
            for (int e = 0; e < NUM_EP; e++) begin
                if (grp == GRP_W'(e + 1)) begin
                    unique case (fld)
                        FLD_EN:   reg_rdata = en_all[e*EP_W +: EP_W];
                        FLD_MASK: reg_rdata = mk_all[e*EP_W +: EP_W];
                        FLD_STAT: reg_rdata = st_all[e*EP_W +: EP_W];
                        FLD_NONE: reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign irq_out = |pend_all;

    msi_prio_enc #(.NUM_EP(NUM_EP)) u_prio (
        .pend   (pend_all),
        .valid  (pend_valid),
        .ep     (pend_ep),
        .bit_no (pend_bit)
    );
endmodule

// File: rtl/msi_ctrl_chk.sv
module msi_ctrl_chk
    import msi_ctrl_pkg::*;
#(
    parameter int NUM_EP = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     msi_valid,
    input logic [63:0]              msi_addr,
    input logic [31:0]              msi_data,
    input logic [DW-1:0]            addr_lo_q,
    input logic [DW-1:0]            addr_hi_q,
    input logic [NUM_EP*EP_W-1:0]   en_all,
    input logic [NUM_EP*EP_W-1:0]   mk_all,
    input logic [NUM_EP*EP_W-1:0]   st_all,
    input logic                     irq_out,
    input logic                     pend_valid,
    input logic [EP_IDX_W-1:0]      pend_ep,
    input logic [BIT_IDX_W-1:0]     pend_bit
);
    logic       match;
    logic       in_rng;
    logic [7:0] idx;
    logic [7:0] pidx;

    assign match  = (msi_addr == {addr_hi_q, addr_lo_q});
    assign in_rng = (int'(msi_data[7:5]) < NUM_EP);
    assign idx    = msi_data[7:0];
    assign pidx   = {pend_ep, pend_bit};

    p_msi_set_r3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && match && in_rng && en_all[idx] |=> st_all[$past(idx)]);

    p_disabled_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && in_rng && !en_all[idx] && !st_all[idx] |=> !st_all[$past(idx)]);

    p_mismatch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && !match && in_rng && !st_all[idx] |=> !st_all[$past(idx)]);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_valid |=> ((st_all & ~$past(st_all)) == '0));

    p_irq_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == pend_valid);

    p_pend_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (st_all[pidx] && !mk_all[pidx]));
endmodule

bind msi_ctrl msi_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msi_valid  (msi_valid),
    .msi_addr   (msi_addr),
    .msi_data   (msi_data),
    .addr_lo_q  (addr_lo_q),
    .addr_hi_q  (addr_hi_q),
    .en_all     (en_all),
    .mk_all     (mk_all),
    .st_all     (st_all),
    .irq_out    (irq_out),
    .pend_valid (pend_valid),
    .pend_ep    (pend_ep),
    .pend_bit   (pend_bit)
);

// File: tb/test_msi_ctrl.sv
module test_msi_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic        pend_valid;
    logic [2:0]  pend_ep;
    logic [4:0]  pend_bit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [31:0] TGT = 32'hF000_0040;

    typedef struct {
        bit          chk_rd;
        logic [31:0] rd;
        bit          chk_p;
        logic        irq;
        logic        pv;
        logic [2:0]  ep;
        logic [4:0]  bt;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t it;

    always #5 clk = ~clk;

    msi_ctrl i_msi_ctrl (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .pend_valid(pend_valid), .pend_ep(pend_ep), .pend_bit(pend_bit)
    );

    // monitor: pops the expected item and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            it = sb.pop_front();
            n_run++;
            if (it.chk_rd && reg_rdata !== it.rd) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.rd);
            end
            if (it.chk_p && {irq_out, pend_valid, pend_ep, pend_bit} !==
                            {it.irq, it.pv, it.ep, it.bt}) begin
                n_fail++;
                $display("FAIL %s: irq=%b pv=%b ep=%0d bit=%0d expected irq=%b pv=%b ep=%0d bit=%0d",
                         it.tag, irq_out, pend_valid, pend_ep, pend_bit,
                         it.irq, it.pv, it.ep, it.bt);
            end
        end
    end

    function automatic logic [5:0] a_en(int e);   return 6'(4 + 4*e); endfunction
    function automatic logic [5:0] a_mk(int e);   return 6'(5 + 4*e); endfunction
    function automatic logic [5:0] a_st(int e);   return 6'(6 + 4*e); endfunction
    function automatic logic [31:0] dat(int e, int b); return 32'((e << 5) | b); endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic msi(input logic [63:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        msi_valid = 1; msi_addr = a; msi_data = d;
        @(posedge clk); #1;
        msi_valid = 0;
    endtask

    task automatic msi_and_wr(input logic [31:0] d, input logic [5:0] a, input logic [31:0] w);
        @(posedge clk); #1;
        msi_valid = 1; msi_addr = {32'h0, TGT}; msi_data = d;
        reg_we = 1; reg_addr = a; reg_wdata = w;
        @(posedge clk); #1;
        msi_valid = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t x;
        x = '{chk_rd: 1, rd: e, chk_p: 0, irq: 0, pv: 0, ep: 0, bt: 0, tag: tag};
        reg_addr = a;
        sb.push_back(x);
        @(negedge clk); #1;
    endtask

    task automatic pchk(input logic i, input logic v, input logic [2:0] e,
                        input logic [4:0] b, input string tag);
        item_t x;
        x = '{chk_rd: 0, rd: 0, chk_p: 1, irq: i, pv: v, ep: e, bt: b, tag: tag};
        sb.push_back(x);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(a_en(0), 32'h0, "R1 enable0 reset");
        rd(a_st(7), 32'h0, "R1 status7 reset");
        rd(6'd0, 32'h0, "R1 target low reset");
        pchk(0, 0, 0, 0, "R1 outputs reset");
        // R9 programming and read-back
        wr(6'd0, TGT);
        wr(6'd1, 32'h0);
        wr(a_en(2), 32'h8000_0001);
        wr(a_en(5), 32'hFFFF_FFFF);
        rd(6'd0, TGT, "R9 target low readback");
        rd(a_en(2), 32'h8000_0001, "R9 enable2 readback");
        // R3 decode, R7 report
        msi({32'h0, TGT}, dat(2, 31));
        rd(a_st(2), 32'h8000_0000, "R3 status2 bit31 set");
        pchk(1, 1, 2, 31, "R7 first pending ep2 bit31");
        // R2 address mismatch in either half
        msi({32'h0, TGT ^ 32'h4}, dat(5, 3));
        msi({32'h1, TGT}, dat(5, 3));
        rd(a_st(5), 32'h0, "R2 mismatched writes dropped");
        // R4 not enabled
        msi({32'h0, TGT}, dat(2, 4));
        rd(a_st(2), 32'h8000_0000, "R4 disabled bit dropped");
        // R7 ordering across and within endpoints
        msi({32'h0, TGT}, dat(5, 9));
        rd(a_st(5), 32'h0000_0200, "R3 status5 bit9 set");
        pchk(1, 1, 2, 31, "R7 lower endpoint wins");
        msi({32'h0, TGT}, dat(2, 0));
        pchk(1, 1, 2, 0, "R7 lower bit wins");
        // R6 mask
        wr(a_mk(2), 32'hFFFF_FFFF);
        rd(a_mk(2), 32'hFFFF_FFFF, "R9 mask2 readback");
        rd(a_st(2), 32'h8000_0001, "R6 masked status kept");
        pchk(1, 1, 5, 9, "R6 masked endpoint skipped");
        // R10 level held with idle bus
        repeat (4) @(posedge clk);
        #1 pchk(1, 1, 5, 9, "R10 level held");
        // R5 write-one-to-clear
        wr(a_st(5), 32'h0000_0200);
        rd(a_st(5), 32'h0, "R5 status5 cleared");
        pchk(0, 0, 0, 0, "R6 R10 irq drops, only masked remain");
        wr(a_st(2), 32'h0000_0001);
        rd(a_st(2), 32'h8000_0000, "R5 only written bit cleared");
        // R8 set and clear collide
        msi({32'h0, TGT}, dat(5, 1));
        rd(a_st(5), 32'h0000_0002, "R8 setup bit1");
        msi_and_wr(dat(5, 9), a_st(5), 32'h0000_0202);
        rd(a_st(5), 32'h0000_0200, "R8 set wins, other bit cleared");
        // unmask, then clear everything
        wr(a_mk(2), 32'h0);
        pchk(1, 1, 2, 31, "R6 unmask restores ep2");
        wr(a_st(2), 32'hFFFF_FFFF);
        wr(a_st(5), 32'hFFFF_FFFF);
        pchk(0, 0, 0, 0, "R5 all cleared, irq low");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule